// File: doc/BRIEF.md
# Password-Guarded Watchdog Control Word

This block holds a watchdog control word. One bit of it, the init-done flag, locks a group of system-critical registers elsewhere in the chip. When the flag is 0, the block raises a write-enable for that group. The word cannot be changed by a single store. Software must first send an open write. That write carries a fixed key, and two of its bits must echo the live DR and IR status bits of a companion configuration register. The very next access must be a commit write that carries a second key pattern. The commit write sets the new flag value and closes the word again. If the key is wrong, or if anything else happens between the two writes, the word stays as it was and a sticky error bit is set.

When the flag goes from 1 to 0, a 16-bit down-counter starts from a fixed reload value. Each service strobe sets the counter back to that reload value. Setting the flag back to 1 stops the counter. If the counter runs out while the flag is still 0, the block pulses a reset request for one cycle and forces the flag back to 1. Software usually waits for the flag to read 0 and services the watchdog while it waits.

Top module: `wdg_guard`

## Requirements
- R1: After reset, the read word has the init-done flag (bit 0) = 1, the closed bit (bit 1) = 1 and the error bit (bit 8) = 0. `rst_req_o` is 0 and `prot_we_o` is 0.
- R2: While the word is closed, an open write needs all of the following: bits 7:4 = 4'b1111, bit 3 = `stat_dr_i`, bit 2 = `stat_ir_i`, bit 1 = 0 and bits 31:8 = 0. Such a write clears the closed bit and leaves the flag unchanged.
- R3: While the word is closed, any write that is not a valid open write changes neither the flag nor the closed bit, and it sets the error bit.
- R4: While the word is open, a commit write needs bits 7:4 = 4'b1111, bits 3:2 = 2'b00, bit 1 = 1 and bits 31:8 = 0. Such a write copies its bit 0 into the flag and closes the word.
- R5: While the word is open, a write that is not a valid commit write leaves the flag unchanged, sets the error bit and closes the word. A read (`rd_en_i`) closes the word without setting the error bit.
- R6: `prot_we_o` always equals the inverse of the flag as read in bit 0.
- R7: A commit write that takes the flag from 1 to 0 loads the counter with TIMEOUT. If no service strobe comes, `rst_req_o` is 1 for exactly one cycle, TIMEOUT+1 clock edges after the edge that took the write, and from that edge on the flag reads 1.
- R8: While the flag is 0, a service strobe taken at a clock edge reloads the counter, so the reset request comes TIMEOUT+1 edges after that strobe.
- R9: Setting the flag back to 1 before the counter runs out stops the counter, and no reset request follows.
- R10: Read data bits 7:2 and 31:9 always read 0.
- R11: The error bit stays set until reset, including across later valid open and commit writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; counts as an access for the open/commit sequence |
| rd_data_o | output | 32 | Current control word |
| stat_dr_i | input | 1 | Live DR status bit from the companion register |
| stat_ir_i | input | 1 | Live IR status bit from the companion register |
| service_i | input | 1 | Watchdog service strobe |
| prot_we_o | output | 1 | Write-enable for the protected registers |
| rst_req_o | output | 1 | One-cycle reset request on time-out |

## Verification
The assertions assume that `wr_en_i` and `rd_en_i` are never high in the same cycle, and that the status bits hold steady through the cycle of an open write. The bench drives each access as a single-cycle strobe with the other strobe low. It changes `stat_dr_i` and `stat_ir_i` only between accesses. Time-out windows are counted in clock edges from the edge that took the clearing write or the service strobe, so the reset pulse is checked both on its exact cycle and on the cycles next to it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W   = 32;
    localparam int BIT_DONE = 0;
    localparam int BIT_SHUT = 1;
    localparam int BIT_ERR  = 8;
    localparam int KEY_LO   = 2;
    localparam int KEY_HI_L = 4;
    localparam int KEY_HI_W = 4;
    localparam logic [KEY_HI_W-1:0] KEY_HI = '1;

    typedef struct packed {
        logic done;
        logic shut;
        logic err;
        logic rst_req;
    } guard_state_t;

endpackage

// File: rtl/wdg_key_check.sv
module wdg_key_check
    import wdg_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic              dr_i,
    input  logic              ir_i,
    output logic              open_ok_o,
    output logic              commit_ok_o
);
    localparam int RSV_L = KEY_HI_L + KEY_HI_W;

    logic hi_ok;
    logic rsv_ok;
    logic lo_echo;
    logic lo_zero;

    always_comb begin
        hi_ok       = data_i[KEY_HI_L +: KEY_HI_W] == KEY_HI;
        rsv_ok      = data_i[DATA_W-1:RSV_L] == '0;
        lo_echo     = (data_i[KEY_LO+1] == dr_i) && (data_i[KEY_LO] == ir_i);
        lo_zero     = data_i[KEY_LO +: 2] == 2'b00;
        open_ok_o   = hi_ok && rsv_ok && lo_echo && !data_i[BIT_SHUT];
        commit_ok_o = hi_ok && rsv_ok && lo_zero && data_i[BIT_SHUT];
    end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
    parameter int                CNT_W  = 16,
    parameter logic [CNT_W-1:0]  RELOAD = 16'd1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_i,
    input  logic svc_i,
    output logic expire_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = RELOAD;
        end else if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == '0) begin
            cnt_d = '0;
        end else if (svc_i) begin
            cnt_d = RELOAD;
        end else begin
            cnt_d = cnt_q - ONE;
        end
    end

    assign expire_o = run_i && !start_i && (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] TIMEOUT = 16'd1000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              stat_dr_i,
    input  logic              stat_ir_i,
    input  logic              service_i,
    output logic              prot_we_o,
    output logic              rst_req_o
);
    guard_state_t st_d, st_q;
    logic open_ok, commit_ok;
    logic start, expire;

    wdg_key_check u_key (
        .data_i      (wr_data_i),
        .dr_i        (stat_dr_i),
        .ir_i        (stat_ir_i),
        .open_ok_o   (open_ok),
        .commit_ok_o (commit_ok)
    );

    assign start = wr_en_i && !st_q.shut && commit_ok
                 && !wr_data_i[BIT_DONE] && st_q.done;

    wdg_timer #(.CNT_W(CNT_W), .RELOAD(TIMEOUT)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .run_i    (!st_q.done),
        .svc_i    (service_i),
        .expire_o (expire)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (wr_en_i) begin
            if (st_q.shut) begin
                if (open_ok) st_d.shut = 1'b0;
                else         st_d.err  = 1'b1;
            end else begin
                st_d.shut = 1'b1;
                if (commit_ok) st_d.done = wr_data_i[BIT_DONE];
                else           st_d.err  = 1'b1;
            end
        end else if (rd_en_i && !st_q.shut) begin
            st_d.shut = 1'b1;
        end
        if (expire) begin
            st_d.rst_req = 1'b1;
            st_d.done    = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{done: 1'b1, shut: 1'b1, err: 1'b0, rst_req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o           = '0;
        rd_data_o[BIT_DONE] = st_q.done;
        rd_data_o[BIT_SHUT] = st_q.shut;
        rd_data_o[BIT_ERR]  = st_q.err;
    end

    assign prot_we_o = !st_q.done;
    assign rst_req_o = st_q.rst_req;

    // R3: a rejected write while closed changes nothing but the error bit
    p_closed_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && st_q.shut && !open_ok && !expire)
        |=> (rd_data_o[BIT_ERR] && rd_data_o[BIT_SHUT] && $stable(rd_data_o[BIT_DONE])));

    // R4/R5: any write while open closes the word
    p_open_write_closes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !st_q.shut) |=> rd_data_o[BIT_SHUT]);

    // R11: the error bit is sticky
    p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[BIT_ERR] |=> rd_data_o[BIT_ERR]);

    // R7: the reset request lasts one cycle
    p_rst_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    // R7: the reset request comes with the flag restored
    p_rst_restores_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> (rd_data_o[BIT_DONE] && $past(prot_we_o)));

    // R9: no reset request while the flag was already set
    p_no_rst_when_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[BIT_DONE] && !start) |=> !rst_req_o);

endmodule

// File: tb/wdg_guard_tb_top.sv
module wdg_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        dr = 1'b0;
    logic        ir = 1'b0;
    logic        svc = 1'b0;
    logic        prot_we;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_guard #(.CNT_W(16), .TIMEOUT(16'(TO))) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_data_o(rd_data), .stat_dr_i(dr), .stat_ir_i(ir),
        .service_i(svc), .prot_we_o(prot_we), .rst_req_o(rst_req));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] open_word(input logic flag);
        return {24'h0, 4'hF, dr, ir, 1'b0, flag};
    endfunction

    function automatic logic [31:0] commit_word(input logic flag);
        return {24'h0, 4'hF, 2'b00, 1'b1, flag};
    endfunction

    task automatic t_reset_state();
        do_reset();
        chk("R1 word", rd_data, 32'h3);
        chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
        chk("R1 prot_we", {31'h0, prot_we}, 32'h0);
        chk("R10 reserved bits", rd_data & 32'hFFFF_FEFC, 32'h0);
    endtask

    task automatic t_open_commit();
        do_reset();
        dr = 1'b1; ir = 1'b0;
        wr(open_word(1'b1));
        chk("R2 open clears closed bit", rd_data, 32'h1);
        wr(commit_word(1'b0));
        chk("R4 commit clears flag and closes", rd_data, 32'h2);
        chk("R6 prot_we high", {31'h0, prot_we}, 32'h1);
        dr = 1'b0; ir = 1'b1;
        wr(open_word(1'b0));
        chk("R2 open with other status", rd_data, 32'h0);
        wr(commit_word(1'b1));
        chk("R4 commit sets flag", rd_data, 32'h3);
        chk("R6 prot_we low", {31'h0, prot_we}, 32'h0);
        chk("R9 no reset after set", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_bad_open();
        do_reset();
        dr = 1'b1; ir = 1'b0;
        wr({24'h0, 4'hF, 2'b01, 1'b0, 1'b1});
        chk("R3 wrong status echo ignored", rd_data, 32'h103);
        wr(commit_word(1'b0));
        chk("R3 commit while closed ignored", rd_data, 32'h103);
        do_reset();
        wr({24'h0, 4'h7, dr, ir, 1'b0, 1'b1});
        chk("R3 wrong key ignored", rd_data, 32'h103);
        do_reset();
        wr(open_word(1'b1) | 32'h0001_0000);
        chk("R2 reserved bits must be zero", rd_data, 32'h103);
    endtask

    task automatic t_bad_commit();
        do_reset();
        dr = 1'b0; ir = 1'b0;
        wr(open_word(1'b1));
        wr({24'h0, 4'hF, 2'b01, 1'b1, 1'b0});
        chk("R5 bad commit ignored and closes", rd_data, 32'h103);
        chk("R5 prot_we stays low", {31'h0, prot_we}, 32'h0);
        do_reset();
        wr(open_word(1'b1));
        rd();
        chk("R5 read closes without error", rd_data, 32'h3);
        wr(commit_word(1'b0));
        chk("R5 late commit rejected", rd_data, 32'h103);
        wr(open_word(1'b1));
        wr(commit_word(1'b0));
        chk("R11 error stays after valid sequence", rd_data, 32'h102);
        wr(open_word(1'b0));
        wr(commit_word(1'b1));
    endtask

    task automatic t_expire();
        do_reset();
        wr(open_word(1'b1));
        wr(commit_word(1'b0));
        idle(TO);
        chk("R7 no reset at edge TO", {31'h0, rst_req}, 32'h0);
        chk("R7 flag still clear", rd_data, 32'h2);
        idle(1);
        chk("R7 reset at edge TO+1", {31'h0, rst_req}, 32'h1);
        chk("R7 flag restored", rd_data, 32'h3);
        idle(1);
        chk("R7 reset lasts one cycle", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_service();
        do_reset();
        wr(open_word(1'b1));
        wr(commit_word(1'b0));
        idle(20);
        @(negedge clk); svc = 1'b1;
        @(negedge clk); svc = 1'b0;
        idle(TO);
        chk("R8 no reset before reloaded window", {31'h0, rst_req}, 32'h0);
        chk("R8 flag still clear", rd_data, 32'h2);
        idle(1);
        chk("R8 reset after reloaded window", {31'h0, rst_req}, 32'h1);
    endtask

    task automatic t_stop();
        logic seen;
        do_reset();
        wr(open_word(1'b1));
        wr(commit_word(1'b0));
        idle(10);
        wr(open_word(1'b0));
        wr(commit_word(1'b1));
        seen = 1'b0;
        for (int i = 0; i < TO + 10; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
        end
        chk("R9 no reset after flag set", {31'h0, seen}, 32'h0);
        chk("R9 flag kept", rd_data, 32'h3);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_open_commit();
        t_bad_open();
        t_bad_commit();
        t_expire();
        t_service();
        t_stop();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule